// File: doc/BRIEF.md
# Configuration Word Guard

The block keeps the device configuration word in a register pair: an active copy and a shadow copy that holds the bitwise inverse. Both copies are written together from a load strobe, which normally comes from the start-up fetch of the configuration location in program memory. A comparator checks every bit pair on every cycle. If any pair stops disagreeing, which is what a single upset cell produces, the block enters a trapped state. In that state it holds a configuration-mismatch reset request until the next full reset.

Two active-low protection fields in the active word drive the access gates. When the code-protect field (bit 13) holds 0, it denies read and write requests that arrive on the external programming/debug port. When the write-protect field (bit 12) holds 0, it denies self-write and erase requests from running code. Instruction fetches are never gated. External requests count only while the mode input reports programming/debug mode. A denied external read returns zeros. Any denied request raises a one-cycle violation pulse in the following cycle.

A four-state controller sequences the block. Its states are WAIT_LOAD, CAPTURE, WATCH and TRIPPED. Its transitions are: T_LOAD, a load from WAIT_LOAD or WATCH that goes to CAPTURE; T_RELOAD, a load in CAPTURE that stays in CAPTURE; T_SETTLE, CAPTURE to WATCH; T_UPSET, a mismatch in WAIT_LOAD or WATCH that goes to TRIPPED; and T_HOLD, which keeps the controller in TRIPPED until reset.

Top module: `cfgword_guard`

## Requirements
- R1: After reset the controller is in WAIT_LOAD, the active word is the erased value 16'hFFFF, and neither the reset request nor the violation flag is asserted.
- R2: A load strobe outside TRIPPED writes `ld_word` into the active copy and its inverse into the shadow copy at the same clock edge. The new protection fields govern the gates from the next cycle on.
- R3: With a configuration loaded (CAPTURE or WATCH) and `prog_mode`=1, external read and write requests are granted when bit 13 is 1 and denied when bit 13 is 0.
- R4: `ext_rd_data` equals `mem_rd_data` while an external read is granted, and is all zeros otherwise.
- R5: Internal write and erase requests are granted when bit 12 is 1 and denied when bit 12 is 0.
- R6: `fetch_gnt` follows `fetch_req` in every state and for every configuration value.
- R7: While `prog_mode`=0, external requests are ignored: they are not granted and they raise no violation.
- R8: `access_viol` is high in the cycle after a cycle in which any counted request was denied, and low otherwise.
- R9: In WAIT_LOAD or WATCH, when any active bit equals its shadow bit, `cfg_rst_req` is asserted from the next cycle.
- R10: Once asserted, `cfg_rst_req` stays high until reset. In TRIPPED, loads are ignored and external requests, internal writes and internal erases are denied.
- R11: Before the first load (WAIT_LOAD), external requests in programming mode are denied.
- R12: Any sequence of loads, including back-to-back strobes with different words, never asserts `cfg_rst_req` when no cell is disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low full reset |
| prog_mode | input | 1 | 1 = external programming/debug mode |
| ld_strobe | input | 1 | Load the configuration word |
| ld_word | input | 16 | Configuration word from nonvolatile storage |
| ext_rd_req | input | 1 | External read request |
| ext_wr_req | input | 1 | External write request |
| int_wr_req | input | 1 | Internal self-write request |
| int_er_req | input | 1 | Internal erase request |
| fetch_req | input | 1 | Instruction fetch request |
| mem_rd_data | input | 16 | Data read from program memory |
| ext_rd_gnt | output | 1 | External read granted |
| ext_wr_gnt | output | 1 | External write granted |
| int_wr_gnt | output | 1 | Internal write granted |
| int_er_gnt | output | 1 | Internal erase granted |
| fetch_gnt | output | 1 | Fetch granted |
| ext_rd_data | output | 16 | Gated external read data |
| access_viol | output | 1 | One-cycle pulse after a denied request |
| cfg_rst_req | output | 1 | Configuration mismatch reset request |

## Verification
The bench flips one shadow bit while the controller watches. A design that compared the wrong polarity or missed a single bit would never raise the reset request. One that cleared the request on a later load would let a disturbed word reach the gates again. Back-to-back reloads with different words are applied to expose a comparator that is not suppressed during the load cycle, because such a design would trip spuriously. The bench also drives external requests outside programming mode and before the first load, fetches under code protection, and denied reads whose data must read as zeros. A swapped bit position or a missing mode qualifier shows up there as a wrong grant or a stray violation pulse.

// File: rtl/cfgguard_pkg.sv
package cfgguard_pkg;

    typedef enum logic [1:0] {
        ST_WAIT_LOAD = 2'd0,
        ST_CAPTURE   = 2'd1,
        ST_WATCH     = 2'd2,
        ST_TRIPPED   = 2'd3
    } guard_state_e;

    localparam int unsigned DEF_CFG_W   = 16;
    localparam int unsigned DEF_CP_BIT  = 13;
    localparam int unsigned DEF_WRP_BIT = 12;

endpackage

// File: rtl/cfgguard_store.sv
module cfgguard_store #(
    parameter int unsigned CFG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [CFG_W-1:0] ld_word,
    output logic [CFG_W-1:0] act_word,
    output logic [CFG_W-1:0] shd_word
);

    localparam logic [CFG_W-1:0] ERASED = {CFG_W{1'b1}};

    logic [CFG_W-1:0] active_q;
    logic [CFG_W-1:0] shadow_q;

    // Both copies are written at the same edge so they never disagree
    // because of the load itself.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= ERASED;
            shadow_q <= ~ERASED;
        end else if (ld_en) begin
            active_q <= ld_word;
            shadow_q <= ~ld_word;
        end
    end

    assign act_word = active_q;
    assign shd_word = shadow_q;

endmodule

// File: rtl/cfgguard_cmp.sv
module cfgguard_cmp #(
    parameter int unsigned CFG_W = 16
) (
    input  logic [CFG_W-1:0] act_word,
    input  logic [CFG_W-1:0] shd_word,
    output logic             mismatch
);

    logic [CFG_W-1:0] pair_ok;

    // A healthy bit pair always holds opposite values.
    genvar gi;
    generate
        for (gi = 0; gi < CFG_W; gi++) begin : g_pair
            assign pair_ok[gi] = act_word[gi] ^ shd_word[gi];
        end
    endgenerate

    assign mismatch = ~&pair_ok;

endmodule

// File: rtl/cfgguard_seq.sv
module cfgguard_seq
    import cfgguard_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_strobe,
    input  logic         mismatch,
    output guard_state_e state,
    output logic         ld_accept,
    output logic         cfg_valid,
    output logic         tripped
);

    guard_state_e st_q;
    guard_state_e st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_WAIT_LOAD;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state. A load wins over a mismatch in the same cycle,
    // because the load rewrites both copies consistently.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_WAIT_LOAD: begin
                if (ld_strobe)     st_d = ST_CAPTURE;   // T_LOAD
                else if (mismatch) st_d = ST_TRIPPED;   // T_UPSET
            end
            ST_CAPTURE: begin
                if (ld_strobe)     st_d = ST_CAPTURE;   // T_RELOAD
                else               st_d = ST_WATCH;     // T_SETTLE
            end
            ST_WATCH: begin
                if (ld_strobe)     st_d = ST_CAPTURE;   // T_LOAD
                else if (mismatch) st_d = ST_TRIPPED;   // T_UPSET
            end
            ST_TRIPPED: begin
                st_d = ST_TRIPPED;                      // T_HOLD
            end
            default: st_d = ST_TRIPPED;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        ld_accept = 1'b0;
        cfg_valid = 1'b0;
        tripped   = 1'b0;
        unique case (st_q)
            ST_WAIT_LOAD: ld_accept = ld_strobe;
            ST_CAPTURE: begin
                ld_accept = ld_strobe;
                cfg_valid = 1'b1;
            end
            ST_WATCH: begin
                ld_accept = ld_strobe;
                cfg_valid = 1'b1;
            end
            ST_TRIPPED: tripped = 1'b1;
            default:    tripped = 1'b1;
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/cfgguard_access.sv
module cfgguard_access #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_mode,
    input  logic              cfg_valid,
    input  logic              tripped,
    input  logic              cp_n,
    input  logic              wrp_n,
    input  logic              ext_rd_req,
    input  logic              ext_wr_req,
    input  logic              int_wr_req,
    input  logic              int_er_req,
    input  logic              fetch_req,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              ext_rd_gnt,
    output logic              ext_wr_gnt,
    output logic              int_wr_gnt,
    output logic              int_er_gnt,
    output logic              fetch_gnt,
    output logic [DATA_W-1:0] ext_rd_data,
    output logic              access_viol
);

    logic ext_rd_live;
    logic ext_wr_live;
    logic ext_ok;
    logic int_ok;
    logic deny_any;
    logic viol_q;

    // External requests count only in programming/debug mode.
    assign ext_rd_live = prog_mode & ext_rd_req;
    assign ext_wr_live = prog_mode & ext_wr_req;

    assign ext_ok = cfg_valid & cp_n & ~tripped;
    assign int_ok = wrp_n & ~tripped;

    assign ext_rd_gnt = ext_rd_live & ext_ok;
    assign ext_wr_gnt = ext_wr_live & ext_ok;
    assign int_wr_gnt = int_wr_req & int_ok;
    assign int_er_gnt = int_er_req & int_ok;
    assign fetch_gnt  = fetch_req;

    assign ext_rd_data = ext_rd_gnt ? mem_rd_data : '0;

    assign deny_any = (ext_rd_live & ~ext_ok) | (ext_wr_live & ~ext_ok)
                    | (int_wr_req & ~int_ok) | (int_er_req & ~int_ok);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_q <= 1'b0;
        end else begin
            viol_q <= deny_any;
        end
    end

    assign access_viol = viol_q;

endmodule

// File: rtl/cfgword_guard.sv
module cfgword_guard
    import cfgguard_pkg::*;
#(
    parameter int unsigned CFG_W   = DEF_CFG_W,
    parameter int unsigned CP_BIT  = DEF_CP_BIT,
    parameter int unsigned WRP_BIT = DEF_WRP_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_mode,
    input  logic             ld_strobe,
    input  logic [CFG_W-1:0] ld_word,
    input  logic             ext_rd_req,
    input  logic             ext_wr_req,
    input  logic             int_wr_req,
    input  logic             int_er_req,
    input  logic             fetch_req,
    input  logic [CFG_W-1:0] mem_rd_data,
    output logic             ext_rd_gnt,
    output logic             ext_wr_gnt,
    output logic             int_wr_gnt,
    output logic             int_er_gnt,
    output logic             fetch_gnt,
    output logic [CFG_W-1:0] ext_rd_data,
    output logic             access_viol,
    output logic             cfg_rst_req
);

    guard_state_e     st;
    logic             ld_accept;
    logic             cfg_valid;
    logic             tripped;
    logic             mismatch;
    logic [CFG_W-1:0] cfg_act;
    logic [CFG_W-1:0] cfg_shd;

    cfgguard_store #(.CFG_W(CFG_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (ld_accept),
        .ld_word  (ld_word),
        .act_word (cfg_act),
        .shd_word (cfg_shd)
    );

    cfgguard_cmp #(.CFG_W(CFG_W)) u_cmp (
        .act_word (cfg_act),
        .shd_word (cfg_shd),
        .mismatch (mismatch)
    );

    cfgguard_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_strobe (ld_strobe),
        .mismatch  (mismatch),
        .state     (st),
        .ld_accept (ld_accept),
        .cfg_valid (cfg_valid),
        .tripped   (tripped)
    );

    cfgguard_access #(.DATA_W(CFG_W)) u_access (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_mode   (prog_mode),
        .cfg_valid   (cfg_valid),
        .tripped     (tripped),
        .cp_n        (cfg_act[CP_BIT]),
        .wrp_n       (cfg_act[WRP_BIT]),
        .ext_rd_req  (ext_rd_req),
        .ext_wr_req  (ext_wr_req),
        .int_wr_req  (int_wr_req),
        .int_er_req  (int_er_req),
        .fetch_req   (fetch_req),
        .mem_rd_data (mem_rd_data),
        .ext_rd_gnt  (ext_rd_gnt),
        .ext_wr_gnt  (ext_wr_gnt),
        .int_wr_gnt  (int_wr_gnt),
        .int_er_gnt  (int_er_gnt),
        .fetch_gnt   (fetch_gnt),
        .ext_rd_data (ext_rd_data),
        .access_viol (access_viol)
    );

    assign cfg_rst_req = tripped;

endmodule

// File: rtl/cfgword_guard_chk.sv
module cfgword_guard_chk
    import cfgguard_pkg::*;
#(
    parameter int unsigned CFG_W   = 16,
    parameter int unsigned CP_BIT  = 13,
    parameter int unsigned WRP_BIT = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             prog_mode,
    input logic [CFG_W-1:0] ld_word,
    input logic             ext_rd_req,
    input logic             ext_wr_req,
    input logic             int_wr_req,
    input logic             int_er_req,
    input logic             fetch_req,
    input logic             ext_rd_gnt,
    input logic             ext_wr_gnt,
    input logic             int_wr_gnt,
    input logic             int_er_gnt,
    input logic             fetch_gnt,
    input logic             access_viol,
    input logic             cfg_rst_req,
    input logic             ld_accept,
    input guard_state_e     st,
    input logic [CFG_W-1:0] cfg_act,
    input logic [CFG_W-1:0] cfg_shd
);

    // R2
    load_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_accept |=> (cfg_act == $past(ld_word)) && (cfg_shd == ~$past(ld_word)));

    // R3
    ext_cp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd_gnt || ext_wr_gnt) |-> cfg_act[CP_BIT]);

    // R5
    int_wrp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr_gnt || int_er_gnt) |-> (cfg_act[WRP_BIT] && !cfg_rst_req));

    // R6
    fetch_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> fetch_gnt);

    // R7
    ext_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rd_gnt || ext_wr_gnt) |-> prog_mode);

    // R8
    viol_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        access_viol |-> $past((prog_mode && ext_rd_req && !ext_rd_gnt)
                           || (prog_mode && ext_wr_req && !ext_wr_gnt)
                           || (int_wr_req && !int_wr_gnt)
                           || (int_er_req && !int_er_gnt)));

    // R9
    upset_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_WATCH) && !ld_accept && ((cfg_act ^ cfg_shd) != {CFG_W{1'b1}}))
        |=> cfg_rst_req);

    // R10
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rst_req |=> cfg_rst_req);

    // R11
    wait_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT_LOAD) |-> !(ext_rd_gnt || ext_wr_gnt));

endmodule

bind cfgword_guard cfgword_guard_chk #(
    .CFG_W   (CFG_W),
    .CP_BIT  (CP_BIT),
    .WRP_BIT (WRP_BIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prog_mode   (prog_mode),
    .ld_word     (ld_word),
    .ext_rd_req  (ext_rd_req),
    .ext_wr_req  (ext_wr_req),
    .int_wr_req  (int_wr_req),
    .int_er_req  (int_er_req),
    .fetch_req   (fetch_req),
    .ext_rd_gnt  (ext_rd_gnt),
    .ext_wr_gnt  (ext_wr_gnt),
    .int_wr_gnt  (int_wr_gnt),
    .int_er_gnt  (int_er_gnt),
    .fetch_gnt   (fetch_gnt),
    .access_viol (access_viol),
    .cfg_rst_req (cfg_rst_req),
    .ld_accept   (ld_accept),
    .st          (st),
    .cfg_act     (cfg_act),
    .cfg_shd     (cfg_shd)
);

// File: tb/cfgword_guard_test.sv
`timescale 1ns/1ps
module cfgword_guard_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_mode = 1'b0;
    logic        ld_strobe = 1'b0;
    logic [15:0] ld_word = '0;
    logic        ext_rd_req = 1'b0;
    logic        ext_wr_req = 1'b0;
    logic        int_wr_req = 1'b0;
    logic        int_er_req = 1'b0;
    logic        fetch_req = 1'b0;
    logic [15:0] mem_rd_data = 16'h5A3C;
    logic        ext_rd_gnt, ext_wr_gnt, int_wr_gnt, int_er_gnt, fetch_gnt;
    logic [15:0] ext_rd_data;
    logic        access_viol, cfg_rst_req;

    int checks = 0;
    int fails  = 0;
    logic [15:0] last_word = 16'hFFFF;

    always #10 clk = ~clk;   // 50 MHz

    cfgword_guard uut (
        .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode),
        .ld_strobe(ld_strobe), .ld_word(ld_word),
        .ext_rd_req(ext_rd_req), .ext_wr_req(ext_wr_req),
        .int_wr_req(int_wr_req), .int_er_req(int_er_req),
        .fetch_req(fetch_req), .mem_rd_data(mem_rd_data),
        .ext_rd_gnt(ext_rd_gnt), .ext_wr_gnt(ext_wr_gnt),
        .int_wr_gnt(int_wr_gnt), .int_er_gnt(int_er_gnt),
        .fetch_gnt(fetch_gnt), .ext_rd_data(ext_rd_data),
        .access_viol(access_viol), .cfg_rst_req(cfg_rst_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic idle_reqs();
        ext_rd_req = 0; ext_wr_req = 0; int_wr_req = 0; int_er_req = 0; fetch_req = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle_reqs();
        ld_strobe = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        last_word = 16'hFFFF;
    endtask

    task automatic load(input logic [15:0] w);
        @(negedge clk);
        ld_strobe = 1; ld_word = w;
        @(negedge clk);
        ld_strobe = 0;
        last_word = w;
    endtask

    task automatic t_reset();
        do_reset();
        prog_mode = 1;
        #2;
        chk("R1 rst_req after reset", cfg_rst_req, 0);
        chk("R1 viol after reset", access_viol, 0);
        ext_rd_req = 1; ext_wr_req = 1; int_wr_req = 1;
        #2;
        chk("R11 ext read before load", ext_rd_gnt, 0);
        chk("R11 ext write before load", ext_wr_gnt, 0);
        chk("R4 data zero before load", ext_rd_data, 0);
        chk("R1 erased word allows int write", int_wr_gnt, 1);
        @(negedge clk); idle_reqs(); #2;
        chk("R8 viol after denied ext", access_viol, 1);
        @(negedge clk); #2;
        chk("R8 viol single cycle", access_viol, 0);
    endtask

    task automatic t_unprotected();
        load(16'hFFFF);
        prog_mode = 1;
        ext_rd_req = 1; ext_wr_req = 1; #2;
        chk("R3 ext read granted cp=1", ext_rd_gnt, 1);
        chk("R3 ext write granted cp=1", ext_wr_gnt, 1);
        chk("R4 read data passes", ext_rd_data, 16'h5A3C);
        mem_rd_data = 16'h0F81; #1;
        chk("R4 read data follows memory", ext_rd_data, 16'h0F81);
        @(negedge clk); idle_reqs(); #2;
        chk("R8 no viol on grant", access_viol, 0);
    endtask

    task automatic t_code_protect();
        load(16'hDFFF);   // bit 13 = 0
        prog_mode = 1;
        ext_rd_req = 1; #2;
        chk("R2 R3 ext read denied cp=0", ext_rd_gnt, 0);
        chk("R4 denied read zero", ext_rd_data, 0);
        @(negedge clk); ext_rd_req = 0; ext_wr_req = 1; int_wr_req = 1; #2;
        chk("R3 ext write denied cp=0", ext_wr_gnt, 0);
        chk("R5 int write unaffected by cp", int_wr_gnt, 1);
        chk("R8 viol after denied read", access_viol, 1);
        @(negedge clk); idle_reqs(); #2;
        chk("R8 viol after denied write", access_viol, 1);
        @(negedge clk); #2;
        chk("R8 viol clears", access_viol, 0);
        fetch_req = 1; #2;
        chk("R6 fetch under code protect", fetch_gnt, 1);
        fetch_req = 0;
    endtask

    task automatic t_write_protect();
        load(16'hEFFF);   // bit 12 = 0
        int_wr_req = 1; int_er_req = 1; #2;
        chk("R5 int write denied wrp=0", int_wr_gnt, 0);
        chk("R5 int erase denied wrp=0", int_er_gnt, 0);
        prog_mode = 1; ext_rd_req = 1; #2;
        chk("R3 ext read ok when only wrp", ext_rd_gnt, 1);
        @(negedge clk); idle_reqs(); #2;
        chk("R8 viol after denied erase", access_viol, 1);
        load(16'hFFFF);
        int_er_req = 1; #2;
        chk("R5 int erase granted wrp=1", int_er_gnt, 1);
        idle_reqs();
    endtask

    task automatic t_mode();
        load(16'hCFFF);   // both protections on
        prog_mode = 0;
        ext_rd_req = 1; ext_wr_req = 1; #2;
        chk("R7 ext read ignored prog_mode=0", ext_rd_gnt, 0);
        chk("R7 ext write ignored prog_mode=0", ext_wr_gnt, 0);
        @(negedge clk); idle_reqs(); #2;
        chk("R7 no viol prog_mode=0", access_viol, 0);
        load(16'hFFFF);
        ext_rd_req = 1; #2;
        chk("R7 no grant prog_mode=0 unprotected", ext_rd_gnt, 0);
        idle_reqs();
        prog_mode = 1;
    endtask

    task automatic t_reload();
        @(negedge clk);
        ld_strobe = 1; ld_word = 16'h1234;
        @(negedge clk); ld_word = 16'hABCD;
        @(negedge clk); ld_word = 16'hFFFF;
        @(negedge clk); ld_strobe = 0; last_word = 16'hFFFF;
        repeat (3) @(negedge clk);
        #2;
        chk("R12 no reset after reloads", cfg_rst_req, 0);
        ext_rd_req = 1; #2;
        chk("R2 last load governs", ext_rd_gnt, 1);
        idle_reqs();
    endtask

    task automatic t_upset();
        load(16'hFFFF);
        repeat (2) @(negedge clk);   // settle into WATCH
        force uut.u_store.shadow_q = ~last_word ^ 16'h0100;
        @(negedge clk);
        release uut.u_store.shadow_q;
        #2;
        chk("R9 reset request after upset", cfg_rst_req, 1);
        load(16'hFFFF);
        repeat (3) @(negedge clk);
        #2;
        chk("R10 reset request sticky", cfg_rst_req, 1);
        prog_mode = 1; ext_rd_req = 1; int_wr_req = 1; int_er_req = 1; #2;
        chk("R10 ext denied when tripped", ext_rd_gnt, 0);
        chk("R10 int write denied when tripped", int_wr_gnt, 0);
        chk("R10 int erase denied when tripped", int_er_gnt, 0);
        idle_reqs();
        do_reset();
        #2;
        chk("R1 reset clears request", cfg_rst_req, 0);
    endtask

    initial begin
        t_reset();
        t_unprotected();
        t_code_protect();
        t_write_protect();
        t_mode();
        t_reload();
        t_upset();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule